// File: doc/BRIEF.md
# Two-Dimensional Nested Page Walker

This block turns a guest virtual address into a system physical address in hardware, for a virtualized machine. The guest keeps its own four-level page table, but every pointer in that table is a guest physical address. So the walker must first send each such pointer through the hypervisor's four-level nested table before it can read the guest entry. When the last guest entry yields the data's guest physical address, one more nested walk produces the final system address. With 4 KB pages at every step, one translation costs 24 memory reads.

A request carries the guest virtual address, the guest table root (a guest physical address) and the nested table root (a system physical address). The walker owns a single read port that allows only one read in flight. It drives an address with a one-cycle `mem_req` strobe and waits for `mem_rsp_valid` with the 64-bit entry. The walk ends in one of two ways: a one-cycle `done` pulse with the address on `spa`, or a one-cycle `fault` pulse.

States: `ST_IDLE` accepts a request and goes to `ST_NEST_REQ`. `ST_NEST_REQ` issues a nested-table read and goes to `ST_NEST_WAIT`. In `ST_NEST_WAIT`, a response leads to one of four places:
- `ST_FAULT`, if the entry is not present.
- `ST_NEST_REQ` again, one level lower, if the entry is not a leaf.
- `ST_GST_REQ`, if the leaf translated a guest table pointer.
- `ST_DONE`, if the leaf translated the data address.

`ST_GST_REQ` issues the guest-entry read and goes to `ST_GST_WAIT`. In `ST_GST_WAIT`, a response goes to `ST_FAULT` if the entry is not present. Otherwise it goes back to `ST_NEST_REQ`, carrying either the next guest table pointer or the data guest physical address. `ST_DONE` and `ST_FAULT` each last one cycle and return to `ST_IDLE`.

Top module: `nested_walker`

## Requirements
- R1: After reset, `busy`, `done`, `fault` and `mem_req` are 0.
- R2: A request is accepted only in idle. `busy` is 1 from the cycle after acceptance up to and including the cycle of the `done` or `fault` pulse, and 0 in the cycle after that.
- R3: `req_valid` asserted while `busy` is 1 has no effect: the running walk finishes with its own result and no second walk follows.
- R4: A walk with 4 KB pages at every guest and nested level makes exactly 24 reads. The result `spa` equals the system frame of the data page joined to bits 11:0 of the guest virtual address.
- R5: At table level L (4 down to 1), the index is address bits [12+9*(L-1) +: 9]. The entry address is the table base plus index*8, and each next table base is entry bits 51:12 with 12 zero bits appended. The first read of a walk goes to the nested root plus the level-4 index of the guest root.
- R6: Each guest table read is preceded by the four nested reads that translate its address. The fifth read of a 4 KB walk goes to the system address of the guest level-4 entry.
- R7: A guest entry at level 2 with bit 7 set maps a 2 MB page and ends the guest walk. Bits 20:0 of the guest virtual address are kept, and the walk makes 19 reads.
- R8: A nested entry at level 2 with bit 7 set ends that nested walk with bits 20:0 of the translated guest physical address kept. For the final data translation this gives 23 reads in total.
- R9: An entry with bit 0 clear at any guest or nested level ends the walk with a `fault` pulse. No further reads are issued, `done` stays 0 and `spa` is 0.
- R10: `done` and `fault` are single-cycle pulses that are never high together. `spa` is nonzero only while `done` is high.
- R11: A new read is never issued in the cycle after a read, and never while a read awaits its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a translation (sampled only in idle) |
| req_gva | input | 48 | Guest virtual address to translate |
| req_guest_root | input | 52 | Guest physical address of the guest level-4 table |
| req_nest_root | input | 52 | System physical address of the nested level-4 table |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse: translation complete |
| fault | output | 1 | One-cycle pulse: non-present entry met |
| spa | output | 52 | Final system physical address, valid with `done` |
| mem_req | output | 1 | One-cycle read strobe |
| mem_addr | output | 52 | Read address, valid with `mem_req` |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Returned table entry |

## Verification
Any wrong level counter, phase flag or base register shows up at the read port within the next read. That read carries the wrong address or comes in the wrong order, or the count of reads per walk departs from 24, 23 or 19. The bench therefore sweeps index combinations at all four guest levels, with expected addresses computed from closed-form mappings. A bad leaf or offset merge shows only on `spa` at the `done` pulse, so every walk compares that value. A broken fault or phase decision shows as a missing pulse, a pulse that comes too early, or a second pulse.

// File: rtl/nwalk_pkg.sv
package nwalk_pkg;
    localparam int ENTRY_W     = 64;
    localparam int PRESENT_BIT = 0;
    localparam int LARGE_BIT   = 7;
    localparam int LARGE_LEVEL = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_NEST_REQ,
        ST_NEST_WAIT,
        ST_GST_REQ,
        ST_GST_WAIT,
        ST_DONE,
        ST_FAULT
    } walk_state_e;
endpackage

// File: rtl/nw_index_pick.sv
module nw_index_pick #(
    parameter int A_W      = 52,
    parameter int LEVELS   = 4,
    parameter int IDX_W    = 9,
    parameter int PG_SHIFT = 12,
    parameter int LVL_W    = 3
) (
    input  logic [A_W-1:0]   addr,
    input  logic [LVL_W-1:0] level,
    output logic [A_W-1:0]   byte_off
);
    logic [IDX_W-1:0] slice [1:LEVELS];
    logic [IDX_W-1:0] idx;
    logic             unused_addr;

    for (genvar l = 1; l <= LEVELS; l++) begin : g_slice
        assign slice[l] = addr[PG_SHIFT + IDX_W*(l-1) +: IDX_W];
    end

    always_comb begin
        idx = '0;
        for (int l = 1; l <= LEVELS; l++) begin
            if (level == LVL_W'(l)) idx = slice[l];
        end
    end

    // entries are 8 bytes
    assign byte_off    = A_W'({idx, 3'b000});
    assign unused_addr = ^addr;
endmodule

// File: rtl/nw_entry_decode.sv
module nw_entry_decode import nwalk_pkg::*; #(
    parameter int PA_W     = 52,
    parameter int PG_SHIFT = 12,
    parameter int IDX_W    = 9,
    parameter int LVL_W    = 3
) (
    input  logic [ENTRY_W-1:0] entry,
    input  logic [LVL_W-1:0]   level,
    input  logic [PA_W-1:0]    xlat_addr,
    output logic               present,
    output logic               big_leaf,
    output logic [PA_W-1:0]    next_base,
    output logic [PA_W-1:0]    leaf_addr
);
    localparam int BIG_SHIFT = PG_SHIFT + IDX_W;
    logic unused_entry;

    assign present   = entry[PRESENT_BIT];
    assign big_leaf  = entry[LARGE_BIT] && (level == LVL_W'(LARGE_LEVEL));
    assign next_base = {entry[PA_W-1:PG_SHIFT], {PG_SHIFT{1'b0}}};
    assign leaf_addr = big_leaf ? {entry[PA_W-1:BIG_SHIFT], xlat_addr[BIG_SHIFT-1:0]}
                                : {entry[PA_W-1:PG_SHIFT],  xlat_addr[PG_SHIFT-1:0]};
    assign unused_entry = ^entry;
endmodule

// File: rtl/nested_walker.sv
module nested_walker import nwalk_pkg::*; #(
    parameter int PA_W     = 52,
    parameter int LEVELS   = 4,
    parameter int IDX_W    = 9,
    parameter int PG_SHIFT = 12,
    parameter int VA_W     = PG_SHIFT + LEVELS*IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [VA_W-1:0]    req_gva,
    input  logic [PA_W-1:0]    req_guest_root,
    input  logic [PA_W-1:0]    req_nest_root,
    output logic               busy,
    output logic               done,
    output logic               fault,
    output logic [PA_W-1:0]    spa,
    output logic               mem_req,
    output logic [PA_W-1:0]    mem_addr,
    input  logic               mem_rsp_valid,
    input  logic [ENTRY_W-1:0] mem_rsp_data
);
    localparam int LVL_W = $clog2(LEVELS + 1);

    walk_state_e       st;
    logic [VA_W-1:0]   gva_r;
    logic [PA_W-1:0]   nroot_r, gpa_tgt, nbase, spa_tgt;
    logic [LVL_W-1:0]  gl, nl;
    logic              last_pass;

    logic [PA_W-1:0]   g_addr, g_off, n_off;
    logic [LVL_W-1:0]  g_lvl, d_lvl;
    logic [PA_W-1:0]   d_addr, d_base, d_leaf;
    logic              d_present, d_big, leaf_hit;

    // guest index: level 4 of the incoming request, else the next guest level
    assign g_addr = (st == ST_IDLE) ? PA_W'(req_gva) : PA_W'(gva_r);
    assign g_lvl  = (st == ST_IDLE) ? LVL_W'(LEVELS) : gl - 1'b1;

    nw_index_pick #(.A_W(PA_W), .LEVELS(LEVELS), .IDX_W(IDX_W),
                    .PG_SHIFT(PG_SHIFT), .LVL_W(LVL_W)) u_gidx (
        .addr(g_addr), .level(g_lvl), .byte_off(g_off));

    nw_index_pick #(.A_W(PA_W), .LEVELS(LEVELS), .IDX_W(IDX_W),
                    .PG_SHIFT(PG_SHIFT), .LVL_W(LVL_W)) u_nidx (
        .addr(gpa_tgt), .level(nl), .byte_off(n_off));

    // one decoder shared by guest and nested responses
    assign d_lvl  = (st == ST_GST_WAIT) ? gl : nl;
    assign d_addr = (st == ST_GST_WAIT) ? PA_W'(gva_r) : gpa_tgt;

    nw_entry_decode #(.PA_W(PA_W), .PG_SHIFT(PG_SHIFT), .IDX_W(IDX_W),
                      .LVL_W(LVL_W)) u_dec (
        .entry(mem_rsp_data), .level(d_lvl), .xlat_addr(d_addr),
        .present(d_present), .big_leaf(d_big),
        .next_base(d_base), .leaf_addr(d_leaf));

    assign leaf_hit = (d_lvl == LVL_W'(1)) || d_big;

    // state register and walk registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            gva_r     <= '0;
            nroot_r   <= '0;
            gpa_tgt   <= '0;
            nbase     <= '0;
            spa_tgt   <= '0;
            gl        <= '0;
            nl        <= '0;
            last_pass <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        gva_r     <= req_gva;
                        nroot_r   <= req_nest_root;
                        nbase     <= req_nest_root;
                        gpa_tgt   <= req_guest_root + g_off;
                        gl        <= LVL_W'(LEVELS);
                        nl        <= LVL_W'(LEVELS);
                        last_pass <= 1'b0;
                        st        <= ST_NEST_REQ;
                    end
                end
                ST_NEST_REQ: st <= ST_NEST_WAIT;
                ST_NEST_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (!d_present) begin
                            st <= ST_FAULT;
                        end else if (leaf_hit) begin
                            spa_tgt <= d_leaf;
                            st      <= last_pass ? ST_DONE : ST_GST_REQ;
                        end else begin
                            nbase <= d_base;
                            nl    <= nl - 1'b1;
                            st    <= ST_NEST_REQ;
                        end
                    end
                end
                ST_GST_REQ: st <= ST_GST_WAIT;
                ST_GST_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (!d_present) begin
                            st <= ST_FAULT;
                        end else begin
                            nbase <= nroot_r;
                            nl    <= LVL_W'(LEVELS);
                            st    <= ST_NEST_REQ;
                            if (leaf_hit) begin
                                gpa_tgt   <= d_leaf;
                                last_pass <= 1'b1;
                            end else begin
                                gpa_tgt <= d_base + g_off;
                                gl      <= gl - 1'b1;
                            end
                        end
                    end
                end
                ST_DONE:  st <= ST_IDLE;
                ST_FAULT: st <= ST_IDLE;
                default:  st <= ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy     = (st != ST_IDLE);
        done     = 1'b0;
        fault    = 1'b0;
        spa      = '0;
        mem_req  = 1'b0;
        mem_addr = '0;
        unique case (st)
            ST_NEST_REQ: begin
                mem_req  = 1'b1;
                mem_addr = nbase + n_off;
            end
            ST_GST_REQ: begin
                mem_req  = 1'b1;
                mem_addr = spa_tgt;
            end
            ST_DONE: begin
                done = 1'b1;
                spa  = spa_tgt;
            end
            ST_FAULT: fault = 1'b1;
            default: ;
        endcase
    end

    // R10
    done_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault)) else $error("done and fault together");

    // R10
    end_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fault) |=> (!done && !fault && !busy)) else $error("end pulse too long");

    // R11
    one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req) else $error("back-to-back read");

    // R11
    wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_NEST_WAIT || st == ST_GST_WAIT) && !mem_rsp_valid) |=> !mem_req)
        else $error("read issued while one outstanding");

    // R2
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid)) else $error("busy without request");
endmodule

// File: tb/tb_nested_walker.sv
module tb_nested_walker;
    localparam logic [51:0] NROOT = 52'h0_0000_9000_0000;
    localparam logic [51:0] GROOT = 52'h0_0000_0010_0000;
    localparam logic [51:0] OFF   = 52'h0_0000_1000_0000;
    localparam logic [51:0] OFF2M = 52'h0_0000_2000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [47:0] req_gva = '0;
    logic        busy, done, fault, mem_req;
    logic [51:0] spa, mem_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;

    int errors = 0;
    int checks = 0;
    int nref = 0;
    int cnt = 0;
    bit finished = 0;
    logic [51:0] raddr [64];
    logic [51:0] cur_addr;
    logic [63:0] mem [logic [51:0]];
    logic [51:0] nalloc = 52'h0_0000_9000_1000;
    logic [51:0] galloc = 52'h0_0000_0010_1000;
    logic [8:0]  vals [4];

    always #10 clk = ~clk;

    nested_walker dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_gva(req_gva),
        .req_guest_root(GROOT), .req_nest_root(NROOT),
        .busy(busy), .done(done), .fault(fault), .spa(spa),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data));

    function automatic logic [8:0] bidx(input logic [51:0] a, input int l);
        return a[12 + 9*(l-1) +: 9];
    endfunction

    function automatic logic [51:0] frame_of(input logic [63:0] e);
        return {e[51:12], 12'h000};
    endfunction

    function automatic logic [63:0] rd(input logic [51:0] a);
        if (mem.exists(a)) return mem[a];
        return 64'h0;
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // memory responder: variable latency, one read at a time
    initial begin
        forever begin
            @(negedge clk);
            if (mem_rsp_valid) mem_rsp_valid = 1'b0;
            if (mem_req) begin
                cur_addr = mem_addr;
                if (nref < 64) raddr[nref] = mem_addr;
                nref++;
                cnt = 1 + (nref % 3);
            end else if (cnt > 0) begin
                cnt--;
                if (cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = rd(cur_addr);
                end
            end
        end
    end

    task automatic nest_map4k(input logic [51:0] gpa);
        logic [51:0] base, ea;
        base = NROOT;
        for (int l = 4; l >= 2; l--) begin
            ea = base + 52'({bidx(gpa, l), 3'b000});
            if (!mem.exists(ea)) begin
                mem[ea] = 64'(nalloc) | 64'h1;
                nalloc  = nalloc + 52'h1000;
            end
            base = frame_of(mem[ea]);
        end
        ea = base + 52'({bidx(gpa, 1), 3'b000});
        mem[ea] = 64'((gpa & ~52'hfff) + OFF) | 64'h1;
    endtask

    task automatic nest_map2m(input logic [51:0] gpa);
        logic [51:0] base, ea;
        base = NROOT;
        for (int l = 4; l >= 3; l--) begin
            ea = base + 52'({bidx(gpa, l), 3'b000});
            if (!mem.exists(ea)) begin
                mem[ea] = 64'(nalloc) | 64'h1;
                nalloc  = nalloc + 52'h1000;
            end
            base = frame_of(mem[ea]);
        end
        ea = base + 52'({bidx(gpa, 2), 3'b000});
        mem[ea] = 64'((gpa & ~52'h1f_ffff) + OFF2M) | 64'h81;
    endtask

    task automatic guest_map(input logic [47:0] gva, input logic [51:0] dgpa,
                             input bit big, input bit do_nest);
        logic [51:0] base, sa, fin;
        int lowest;
        lowest = big ? 2 : 1;
        base = GROOT;
        for (int l = 4; l > lowest; l--) begin
            sa = base + 52'({bidx(52'(gva), l), 3'b000}) + OFF;
            if (!mem.exists(sa)) begin
                mem[sa] = 64'(galloc) | 64'h1;
                nest_map4k(galloc);
                galloc = galloc + 52'h1000;
            end
            base = frame_of(mem[sa]);
        end
        sa = base + 52'({bidx(52'(gva), lowest), 3'b000}) + OFF;
        if (big) begin
            mem[sa] = 64'(dgpa & ~52'h1f_ffff) | 64'h81;
            fin = {dgpa[51:21], gva[20:0]};
        end else begin
            mem[sa] = 64'(dgpa & ~52'hfff) | 64'h1;
            fin = {dgpa[51:12], gva[11:0]};
        end
        if (do_nest) nest_map4k(fin);
    endtask

    task automatic walk(input logic [47:0] gva, input bit inject,
                        output bit got_done, output bit got_fault,
                        output logic [51:0] got_spa, output int refs);
        int cyc;
        got_done = 0; got_fault = 0; got_spa = '0; cyc = 0;
        @(negedge clk);
        nref = 0;
        req_valid = 1'b1;
        req_gva   = gva;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b1, "R2 busy after accept", 64'(busy), 64'h1);
        while (!got_done && !got_fault && cyc < 4000) begin
            if (done) begin
                got_done = 1; got_spa = spa;
                check(fault == 1'b0, "R10 exclusive pulse", 64'(fault), 64'h0);
            end else if (fault) begin
                got_fault = 1;
                check(spa == '0, "R9 spa zero on fault", 64'(spa), 64'h0);
            end else begin
                check(spa == '0, "R10 spa zero before done", 64'(spa), 64'h0);
                if (inject && cyc == 3) begin
                    req_valid = 1'b1;
                    req_gva   = ~gva;
                end
                if (cyc == 4) req_valid = 1'b0;
                @(negedge clk);
                cyc++;
            end
        end
        check(got_done || got_fault, "R2 walk terminates", 64'(cyc), 64'h0);
        @(negedge clk);
        refs = nref;
        check(!done && !fault && !busy, "R10 single-cycle end and R2 busy drop",
              64'({busy, done, fault}), 64'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        bit          d, f;
        logic [51:0] s, exp_s, ea3;
        logic [47:0] gva, g0;
        int          r;

        vals[0] = 9'd0; vals[1] = 9'd1; vals[2] = 9'd255; vals[3] = 9'd511;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!busy && !done && !fault && !mem_req, "R1 reset outputs",
              64'({busy, done, fault, mem_req}), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !fault && !mem_req, "R1 idle after reset",
              64'({busy, done, fault, mem_req}), 64'h0);

        nest_map4k(GROOT);
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++)
                for (int c = 0; c < 4; c++)
                    for (int e = 0; e < 4; e++) begin
                        int n;
                        n = a*64 + b*16 + c*4 + e;
                        gva = {vals[a], vals[b], vals[c], vals[e], 12'((n*37) % 4096)};
                        guest_map(gva, 52'h20_0000 + 52'(n) * 52'h1000, 0, 1);
                    end

        // R4 / R5: sweep over guest indices at all four levels
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++)
                for (int c = 0; c < 4; c++)
                    for (int e = 0; e < 4; e++) begin
                        int n;
                        n = a*64 + b*16 + c*4 + e;
                        gva = {vals[a], vals[b], vals[c], vals[e], 12'((n*37) % 4096)};
                        exp_s = 52'h20_0000 + 52'(n) * 52'h1000 + 52'((n*37) % 4096) + OFF;
                        walk(gva, 0, d, f, s, r);
                        check(d && !f, "R4 done on mapped walk", 64'({d, f}), 64'h2);
                        check(s == exp_s, "R4 spa value", 64'(s), 64'(exp_s));
                        check(r == 24, "R4 read count", 64'(r), 64'd24);
                        if (n == 0) begin
                            // R5 first read: nested root plus index of guest root
                            check(raddr[0] == NROOT + 52'({bidx(GROOT, 4), 3'b000}),
                                  "R5 first read address", 64'(raddr[0]), 64'(NROOT));
                            // R6 fifth read is the guest level-4 entry
                            check(raddr[4] == GROOT + OFF + 52'({vals[0], 3'b000}),
                                  "R6 guest L4 read address", 64'(raddr[4]),
                                  64'(GROOT + OFF));
                        end
                    end

        // R3 request during busy is ignored
        g0 = {vals[1], vals[2], vals[3], vals[0], 12'(((1*64+2*16+3*4)*37) % 4096)};
        exp_s = 52'h20_0000 + 52'(108) * 52'h1000 + 52'((108*37) % 4096) + OFF;
        walk(g0, 1, d, f, s, r);
        check(d && s == exp_s, "R3 result unaffected by second request", 64'(s), 64'(exp_s));
        check(r == 24, "R3 no extra reads", 64'(r), 64'd24);
        repeat (4) @(negedge clk);
        check(!busy && !mem_req, "R3 no second walk started",
              64'({busy, mem_req}), 64'h0);

        // R7 guest 2 MB page
        gva = {9'd5, 9'd0, 9'd3, 21'h1_2345};
        guest_map(gva, 52'h80_0000, 1, 1);
        walk(gva, 0, d, f, s, r);
        exp_s = 52'h81_2345 + OFF;
        check(d && !f, "R7 done on large guest page", 64'({d, f}), 64'h2);
        check(s == exp_s, "R7 spa keeps 21 offset bits", 64'(s), 64'(exp_s));
        check(r == 19, "R7 read count", 64'(r), 64'd19);

        // R8 nested 2 MB mapping for the data page
        gva = {9'd6, 9'd0, 9'd0, 9'd0, 12'habc};
        guest_map(gva, 52'h400_5000, 0, 0);
        nest_map2m(52'h400_0000);
        walk(gva, 0, d, f, s, r);
        exp_s = 52'h2400_5abc;
        check(d && s == exp_s, "R8 spa through nested large page", 64'(s), 64'(exp_s));
        check(r == 23, "R8 read count", 64'(r), 64'd23);

        // R9 guest level-3 entry not present
        g0  = {vals[0], vals[0], vals[0], vals[0], 12'h000};
        ea3 = frame_of(mem[GROOT + OFF]) + OFF;
        mem[ea3] = mem[ea3] & ~64'h1;
        walk(g0, 0, d, f, s, r);
        check(f && !d, "R9 fault on guest entry", 64'({d, f}), 64'h1);
        check(r == 10, "R9 reads stop at fault", 64'(r), 64'd10);
        mem[ea3] = mem[ea3] | 64'h1;
        walk(g0, 0, d, f, s, r);
        check(d && s == 52'h20_0000 + OFF, "R9 restored walk completes",
              64'(s), 64'(52'h20_0000 + OFF));

        // R9 nested level-1 entry missing for the data page
        gva = {9'd7, 9'd0, 9'd0, 9'd0, 12'h010};
        guest_map(gva, 52'h30_0000, 0, 0);
        walk(gva, 0, d, f, s, r);
        check(f && !d, "R9 fault on nested entry", 64'({d, f}), 64'h1);
        check(r == 24, "R9 nested fault read count", 64'(r), 64'd24);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule